// File: doc/BRIEF.md
# UART Internal Loopback Controller

This block handles the self-test path of a UART: when the loopback mode is switched on, the transmit side is folded back into the receive side without leaving the chip. It sits between the control-register write port, the line-control write port, the transmit data write port, the external receiver and the receive queue input. It is not a FIFO. It produces at most one receive-queue push per cycle. It also owns the four modem status flags and their raw interrupt bits.

While loopback is on, every control-register write copies the modem control outputs onto the modem status flags. The mapping is crossed: RI takes OUT2, DCD takes OUT1, CTS takes RTS and DSR takes DTR. The write that turns loopback on is one of these writes. The raw modem interrupt bits are then rebuilt from the new flags. Characters written for transmission are copied into the receive queue. A rising send-break bit in a line-control write produces a break entry. External characters and external break events are dropped in this mode.

With loopback off, the flags follow the modem input pins after a synchroniser. External characters and break events then reach the receive queue.

Top module: `uart_loopback_ctrl`

## Requirements
- R1: After reset, loopback is off, the flags and raw modem interrupt bits are 0, and no receive push is made.
- R2: A control write with the loopback bit set updates `mdm_flags` on the next cycle, with the bit order {RI,DCD,CTS,DSR} = {OUT2,OUT1,RTS,DTR}. This includes the write that first enables loopback.
- R3: After such a write, `ms_raw` equals the new flags exactly: every bit is cleared, then set again where its flag is 1.
- R4: With loopback on, a transmit write pushes its byte to the receive queue on the next cycle with `rxq_err` = 0. In every mode the byte also leaves on `tx_out_*` on the next cycle.
- R5: With loopback on, characters from the external receiver are discarded.
- R6: An external break event pushes a break entry only while loopback is off.
- R7: With loopback on, a line-control write that changes the send-break bit from 0 to 1 pushes one break entry on the next cycle. A break entry has data 0 and `rxq_err` = 4'b0100. Rewriting 1, writing 0, or any send-break write while loopback is off pushes nothing.
- R8: When a break request and a character push fall in the same cycle, the character is pushed first and the break entry follows on the next free cycle.
- R9: With loopback off, `mdm_flags` follows the modem pins {RI,DCD,CTS,DSR} after SYNC_STAGES+1 cycles, and control writes do not remap the flags.
- R10: A bit of `ms_clr` clears the matching `ms_raw` bit. A remapping write in the same cycle takes precedence. No `ms_raw` bit is ever set except by a remapping write.
- R11: With loopback off, an external character is pushed on the next cycle with its error field. The error field layout is overrun bit 3, break bit 2, parity bit 1, framing bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cr_wr | input | 1 | Control register write strobe |
| cr_loop | input | 1 | Written loopback enable bit |
| cr_out2 | input | 1 | Written OUT2 modem output |
| cr_out1 | input | 1 | Written OUT1 modem output |
| cr_rts | input | 1 | Written RTS modem output |
| cr_dtr | input | 1 | Written DTR modem output |
| lcr_wr | input | 1 | Line-control write strobe |
| lcr_brk | input | 1 | Written send-break bit |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | 8 | Transmit byte |
| rx_in_valid | input | 1 | External received character valid |
| rx_in_data | input | 8 | External received byte |
| rx_in_err | input | 4 | External error field |
| rx_in_brk | input | 1 | External break event |
| pin_ri | input | 1 | Asynchronous ring indicator input |
| pin_dcd | input | 1 | Asynchronous carrier detect input |
| pin_cts | input | 1 | Asynchronous clear-to-send input |
| pin_dsr | input | 1 | Asynchronous data-set-ready input |
| ms_clr | input | 4 | Raw modem interrupt clear, {RI,DCD,CTS,DSR} |
| tx_out_valid | output | 1 | Byte to transmitter valid |
| tx_out_data | output | 8 | Byte to transmitter |
| rxq_push | output | 1 | Receive queue push |
| rxq_data | output | 8 | Pushed byte |
| rxq_err | output | 4 | Pushed error field |
| mdm_flags | output | 4 | Modem status flags {RI,DCD,CTS,DSR} |
| ms_raw | output | 4 | Raw modem interrupt bits {RI,DCD,CTS,DSR} |
| loop_active | output | 1 | Loopback mode currently on |

## Verification
Assertions check on every cycle that a remapping write lands in the flags one cycle later. They also check that the raw interrupt bits then equal the flags, that raw bits never rise without a remap, and that a looped transmit write becomes a clean push. Only the bench scenarios can show the following:
- the drop of external traffic in loopback mode;
- the edge-only behaviour of the send-break trigger;
- the ordering of a break behind a colliding character;
- the pin-following path through the synchroniser.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
    typedef struct packed {
        logic ri;
        logic dcd;
        logic cts;
        logic dsr;
    } mdm_t;

    typedef struct packed {
        logic loop;
        logic brk;
    } ctl_t;
endpackage

// File: rtl/uart_lb_sync.sv
module uart_lb_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_comb chain_d[i] = d;
        end else begin : g_next
            always_comb chain_d[i] = chain_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= '0;
            else        chain_q[i] <= chain_d[i];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/uart_lb_modem.sv
module uart_lb_modem
    import uart_lb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       remap,
    input  mdm_t       map_val,
    input  logic       loop_q,
    input  mdm_t       pins_sync,
    input  logic [3:0] ms_clr,
    output mdm_t       flags,
    output logic [3:0] raw
);
    typedef struct packed {
        mdm_t       flags;
        logic [3:0] raw;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (remap) begin
            st_d.raw   = '0;
            st_d.flags = map_val;
            st_d.raw   = st_d.raw | map_val;
        end else begin
            if (!loop_q) st_d.flags = pins_sync;
            st_d.raw = st_q.raw & ~ms_clr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign raw   = st_q.raw;

    assert_remap_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        remap |=> (flags == $past(map_val)));
    assert_raw_rebuilt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        remap |=> (raw == flags));
    assert_raw_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !remap |=> ((raw & ~$past(raw)) == 4'b0000));
endmodule

// File: rtl/uart_lb_rxsel.sv
module uart_lb_rxsel #(
    parameter int DATA_W  = 8,
    parameter int ERR_W   = 4,
    parameter int BRK_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_q,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_in_valid,
    input  logic [DATA_W-1:0] rx_in_data,
    input  logic [ERR_W-1:0]  rx_in_err,
    input  logic              rx_in_brk,
    input  logic              lb_brk_req,
    output logic              push,
    output logic [DATA_W-1:0] data,
    output logic [ERR_W-1:0]  err
);
    typedef struct packed {
        logic              push;
        logic [DATA_W-1:0] data;
        logic [ERR_W-1:0]  err;
        logic              pend;
    } st_t;

    st_t st_d, st_q;
    logic char_v, brk_now;
    logic [DATA_W-1:0] char_d;
    logic [ERR_W-1:0]  char_e;
    logic [ERR_W-1:0]  brk_e;

    always_comb begin
        brk_e          = '0;
        brk_e[BRK_BIT] = 1'b1;
        char_v  = loop_q ? tx_wr   : rx_in_valid;
        char_d  = loop_q ? tx_data : rx_in_data;
        char_e  = loop_q ? '0      : rx_in_err;
        brk_now = lb_brk_req | (rx_in_brk & ~loop_q) | st_q.pend;
        st_d      = st_q;
        st_d.push = 1'b0;
        if (char_v) begin
            st_d.push = 1'b1;
            st_d.data = char_d;
            st_d.err  = char_e;
            st_d.pend = brk_now;
        end else if (brk_now) begin
            st_d.push = 1'b1;
            st_d.data = '0;
            st_d.err  = brk_e;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push = st_q.push;
    assign data = st_q.data;
    assign err  = st_q.err;

    assert_loop_tx_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_q && tx_wr) |=> (push && data == $past(tx_data) && err == '0));
    assert_ext_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_q && !tx_wr && !lb_brk_req && !st_q.pend) |=> !push);
    assert_ext_char_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_q && rx_in_valid) |=> (push && data == $past(rx_in_data)));
endmodule

// File: rtl/uart_loopback_ctrl.sv
module uart_loopback_ctrl
    import uart_lb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ERR_W       = 4,
    parameter int BRK_BIT     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cr_wr,
    input  logic              cr_loop,
    input  logic              cr_out2,
    input  logic              cr_out1,
    input  logic              cr_rts,
    input  logic              cr_dtr,
    input  logic              lcr_wr,
    input  logic              lcr_brk,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_in_valid,
    input  logic [DATA_W-1:0] rx_in_data,
    input  logic [ERR_W-1:0]  rx_in_err,
    input  logic              rx_in_brk,
    input  logic              pin_ri,
    input  logic              pin_dcd,
    input  logic              pin_cts,
    input  logic              pin_dsr,
    input  logic [3:0]        ms_clr,
    output logic              tx_out_valid,
    output logic [DATA_W-1:0] tx_out_data,
    output logic              rxq_push,
    output logic [DATA_W-1:0] rxq_data,
    output logic [ERR_W-1:0]  rxq_err,
    output logic [3:0]        mdm_flags,
    output logic [3:0]        ms_raw,
    output logic              loop_active
);
    typedef struct packed {
        ctl_t              ctl;
        logic              tx_v;
        logic [DATA_W-1:0] tx_d;
    } top_t;

    top_t st_d, st_q;
    logic remap, lb_brk_req;
    mdm_t map_val, pins_sync, flags;
    logic [3:0] pins_raw, pins_q;

    always_comb begin
        st_d      = st_q;
        st_d.tx_v = tx_wr;
        if (tx_wr)  st_d.tx_d     = tx_data;
        if (cr_wr)  st_d.ctl.loop = cr_loop;
        if (lcr_wr) st_d.ctl.brk  = lcr_brk;
        remap      = cr_wr & cr_loop;
        lb_brk_req = lcr_wr & lcr_brk & ~st_q.ctl.brk & st_q.ctl.loop;
        map_val    = '{ri: cr_out2, dcd: cr_out1, cts: cr_rts, dsr: cr_dtr};
        pins_raw   = {pin_ri, pin_dcd, pin_cts, pin_dsr};
        pins_sync  = mdm_t'(pins_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    uart_lb_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_q)
    );

    uart_lb_modem u_modem (
        .clk(clk), .rst_n(rst_n), .remap(remap), .map_val(map_val),
        .loop_q(st_q.ctl.loop), .pins_sync(pins_sync), .ms_clr(ms_clr),
        .flags(flags), .raw(ms_raw)
    );

    uart_lb_rxsel #(.DATA_W(DATA_W), .ERR_W(ERR_W), .BRK_BIT(BRK_BIT)) u_rxsel (
        .clk(clk), .rst_n(rst_n), .loop_q(st_q.ctl.loop),
        .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
        .rx_in_err(rx_in_err), .rx_in_brk(rx_in_brk),
        .lb_brk_req(lb_brk_req),
        .push(rxq_push), .data(rxq_data), .err(rxq_err)
    );

    assign mdm_flags    = flags;
    assign loop_active  = st_q.ctl.loop;
    assign tx_out_valid = st_q.tx_v;
    assign tx_out_data  = st_q.tx_d;

    assert_loop_break_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_brk_req && !tx_wr) |=> (rxq_push && rxq_data == '0 && rxq_err[BRK_BIT]));
    assert_tx_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> (tx_out_valid && tx_out_data == $past(tx_data)));
endmodule

// File: tb/uart_loopback_ctrl_tb_top.sv
module uart_loopback_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cr_wr = 0, cr_loop = 0, cr_out2 = 0, cr_out1 = 0, cr_rts = 0, cr_dtr = 0;
    logic lcr_wr = 0, lcr_brk = 0, tx_wr = 0, rx_in_valid = 0, rx_in_brk = 0;
    logic [7:0] tx_data = 0, rx_in_data = 0;
    logic [3:0] rx_in_err = 0, ms_clr = 0;
    logic pin_ri = 0, pin_dcd = 0, pin_cts = 0, pin_dsr = 0;
    logic tx_out_valid, rxq_push, loop_active;
    logic [7:0] tx_out_data, rxq_data;
    logic [3:0] rxq_err, mdm_flags, ms_raw;
    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_loopback_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cr_wr(cr_wr), .cr_loop(cr_loop),
        .cr_out2(cr_out2), .cr_out1(cr_out1), .cr_rts(cr_rts), .cr_dtr(cr_dtr),
        .lcr_wr(lcr_wr), .lcr_brk(lcr_brk), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_err(rx_in_err),
        .rx_in_brk(rx_in_brk), .pin_ri(pin_ri), .pin_dcd(pin_dcd),
        .pin_cts(pin_cts), .pin_dsr(pin_dsr), .ms_clr(ms_clr),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
        .rxq_push(rxq_push), .rxq_data(rxq_data), .rxq_err(rxq_err),
        .mdm_flags(mdm_flags), .ms_raw(ms_raw), .loop_active(loop_active)
    );

    // entry: {out2,out1,rts,dtr, expected {ri,dcd,cts,dsr}}
    localparam logic [7:0] VEC [0:5] = '{
        8'b1010_1010, 8'b1111_1111, 8'b0001_0001,
        8'b0100_0100, 8'b0000_0000, 8'b1100_1100
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        cr_wr = 0; lcr_wr = 0; tx_wr = 0; rx_in_valid = 0; rx_in_brk = 0; ms_clr = 0;
    endtask

    task automatic cr_write(logic lp, logic [3:0] bits);
        cr_wr = 1; cr_loop = lp;
        {cr_out2, cr_out1, cr_rts, cr_dtr} = bits;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) step();
        chk("R1 flags", mdm_flags, 0);
        chk("R1 raw", ms_raw, 0);
        chk("R1 push", rxq_push, 0);
        chk("R1 loop", loop_active, 0);
        rst_n = 1;
        step();

        // R2/R3 table: the first entry is the enabling write
        foreach (VEC[i]) begin
            cr_write(1'b1, VEC[i][7:4]);
            step();
            idle();
            chk("R2 remap flags", mdm_flags, VEC[i][3:0]);
            chk("R3 raw rebuilt", ms_raw, VEC[i][3:0]);
            chk("R2 loop on", loop_active, 1);
        end

        // R10 clear, and a remap that wins over a clear in the same cycle
        cr_write(1'b1, 4'b1111); step(); idle();
        ms_clr = 4'b0010; step(); idle();
        chk("R10 clear", ms_raw, 4'b1101);
        cr_write(1'b1, 4'b1111); ms_clr = 4'b1111; step(); idle();
        chk("R10 remap wins", ms_raw, 4'b1111);

        // R4 looped transmit
        tx_wr = 1; tx_data = 8'hA5; step(); idle();
        chk("R4 push", rxq_push, 1);
        chk("R4 data", rxq_data, 8'hA5);
        chk("R4 err", rxq_err, 0);
        chk("R4 tx out", {tx_out_valid, tx_out_data}, {1'b1, 8'hA5});

        // R5 external char discarded
        rx_in_valid = 1; rx_in_data = 8'h3C; step(); idle();
        chk("R5 ext dropped", rxq_push, 0);

        // R6 external break blocked in loopback
        rx_in_brk = 1; step(); idle();
        chk("R6 ext brk blocked", rxq_push, 0);
        step();
        chk("R6 no late brk", rxq_push, 0);

        // R7 send-break rising edge
        lcr_wr = 1; lcr_brk = 1; step(); idle();
        chk("R7 brk push", rxq_push, 1);
        chk("R7 brk entry", {rxq_data, rxq_err}, {8'h00, 4'b0100});
        lcr_wr = 1; lcr_brk = 1; step(); idle();
        chk("R7 no repeat", rxq_push, 0);
        lcr_wr = 1; lcr_brk = 0; step(); idle();
        chk("R7 clear no push", rxq_push, 0);

        // R8 collision: character first, then break
        lcr_wr = 1; lcr_brk = 1; tx_wr = 1; tx_data = 8'h77; step(); idle();
        chk("R8 char first", {rxq_push, rxq_data, rxq_err}, {1'b1, 8'h77, 4'b0000});
        step();
        chk("R8 brk next", {rxq_push, rxq_data, rxq_err}, {1'b1, 8'h00, 4'b0100});
        lcr_wr = 1; lcr_brk = 0; step(); idle();

        // loopback off
        cr_write(1'b0, 4'b0000); step(); idle();
        chk("R9 loop off", loop_active, 0);

        // R11 external char
        rx_in_valid = 1; rx_in_data = 8'h5A; rx_in_err = 4'b0001; step(); idle();
        chk("R11 ext push", {rxq_push, rxq_data, rxq_err}, {1'b1, 8'h5A, 4'b0001});
        tx_wr = 1; tx_data = 8'h11; step(); idle();
        chk("R4 no loop push", rxq_push, 0);
        chk("R4 tx out unlooped", {tx_out_valid, tx_out_data}, {1'b1, 8'h11});

        // R6 external break accepted
        rx_in_brk = 1; step(); idle();
        chk("R6 ext brk", {rxq_push, rxq_data, rxq_err}, {1'b1, 8'h00, 4'b0100});

        // R7 send-break with loopback off
        lcr_wr = 1; lcr_brk = 1; step(); idle();
        chk("R7 no push when off", rxq_push, 0);
        lcr_wr = 1; lcr_brk = 0; step(); idle();

        // R9 pins followed, no remap by writes
        {pin_ri, pin_dcd, pin_cts, pin_dsr} = 4'b1010;
        repeat (4) step();
        chk("R9 pins", mdm_flags, 4'b1010);
        cr_write(1'b0, 4'b0101); step(); idle();
        step();
        chk("R9 no remap", mdm_flags, 4'b1010);
        chk("R9 raw kept", ms_raw, 4'b1111);
        ms_clr = 4'b1111; step(); idle();
        chk("R10 clear off", ms_raw, 4'b0000);

        done = 1;
        finish_run();
    end
endmodule